// File: doc/BRIEF.md
# Paced Serial Message Sender with Attention Recovery

This block sends multi-byte messages from a host to a slow peripheral controller over a three-wire serial link: an active-low select, a serial clock and a data-out line. Bytes arrive on a valid/ready stream, each tagged with a flag that marks the final byte of a message. The block shifts each byte out with a shaped clock whose low and high phases have minimum lengths. It spaces the starts of successive bytes a minimum distance apart. It keeps the select asserted for the whole message. After the message it releases the select and then waits for the peripheral to release its attention line. A guard time must then pass before another message can start.

Every time limit is a parameter in system clock cycles. The defaults are derived from a clock-rate parameter given in MHz: 2 µs per clock phase, 150 µs between byte starts, and a 120 µs guard. The stream follows the usual back-pressure rule. A byte moves only in a cycle where both `in_valid` and `in_ready` are high. The source must hold the byte, its flag and `in_valid` steady until that cycle. `in_ready` rises only when the block can begin a byte at once. The peripheral asks to be read by pulling attention low while driving its data line high. The block reports that request on a status output and does nothing else with it.

Top module: `spi_paced_host`

## Requirements
- R1: Each accepted byte is sent as exactly eight serial clock pulses with the most significant bit first. Each bit is placed on `spi_mosi` and is sampled by the peripheral on the rising clock edge.
- R2: Every low phase of `spi_sclk` lasts exactly `SCK_LO_CYC` cycles and every high phase within a byte lasts exactly `SCK_HI_CYC` cycles. Outside a byte, `spi_sclk` rests high.
- R3: `spi_mosi` changes only while `spi_sclk` is low. It is stable for the whole high phase.
- R4: `spi_cs_n` falls when the first byte of a message is accepted. It stays low through all bytes and the gaps between them. It rises only after the final pulse of the byte flagged last.
- R5: Two consecutive byte starts within a message are at least `BYTE_CYC` cycles apart.
- R6: `in_ready` is high only when the block is idle or when it is between bytes of a message and the byte spacing has elapsed. It is low while a byte is being shifted. A byte offered without `in_ready` is not consumed.
- R7: After `spi_cs_n` rises, no new message starts until `periph_attn_n` has been seen high and at least `GUARD_CYC` further cycles have passed.
- R8: `busy` is high from the acceptance of a message's first byte until the guard time has expired. While the select is high and `busy` is high, `in_ready` is low.
- R9: Outside a message, `read_pending` goes high three cycles after `periph_attn_n` is low together with `spi_miso` high. Such a request never starts a transfer. During a message `read_pending` stays low.
- R10: `in_last` on an accepted byte ends the message after that byte. Bytes without the flag keep the select low for more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered on the stream |
| in_data | input | DATA_W | Byte to send |
| in_last | input | 1 | Byte is the final one of its message |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| spi_cs_n | output | 1 | Active-low select to the peripheral |
| spi_sclk | output | 1 | Serial clock, rests high |
| spi_mosi | output | 1 | Serial data to the peripheral |
| periph_attn_n | input | 1 | Active-low attention from the peripheral (asynchronous) |
| spi_miso | input | 1 | Data line from the peripheral (asynchronous) |
| busy | output | 1 | Message or recovery in progress |
| read_pending | output | 1 | Peripheral is asking to be read |

## Verification
The hardest case is a new message that is already waiting while the previous one is still recovering. It tests whether the guard is counted from the attention release and not from the select release. To reach it, the bench holds the first byte of the next message valid right after the select rises. It delays the peripheral's attention release by a varying number of cycles. It then measures the distance from that release to the next select fall. A long idle stretch inside another message checks that byte spacing is a lower bound and not a fixed rate. Holding the data line high during a message checks that a read request is reported only outside messages.

// File: rtl/spi_pace_pkg.sv
package spi_pace_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_WAIT_ATTN,
    ST_GUARD
  } pace_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_pace_counter.sv
// Saturating up-counter with synchronous clear.
module spi_pace_counter #(
  parameter int unsigned MAX_CNT = 255,
  localparam int unsigned CW = $clog2(MAX_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = CW'(MAX_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n)           count <= '0;
    else if (clear)       count <= '0;
    else if (count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/spi_pace_sync.sv
// Multi-stage synchronizer for asynchronous peripheral inputs.
module spi_pace_sync #(
  parameter int unsigned   W       = 2,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_pace_shifter.sv
// Shifts one word out MSB first with a shaped clock that rests high.
module spi_pace_shifter #(
  parameter int unsigned LO_CYC = 2,
  parameter int unsigned HI_CYC = 2,
  parameter int unsigned BITS   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] din,
  output logic            sclk,
  output logic            mosi,
  output logic            done
);
  localparam int unsigned PH_MAX = spi_pace_pkg::umax(LO_CYC, HI_CYC);
  localparam int unsigned PW     = $clog2(PH_MAX + 1);
  localparam int unsigned BW     = $clog2(BITS);
  localparam logic [PW-1:0] LO_END   = PW'(LO_CYC - 1);
  localparam logic [PW-1:0] HI_END   = PW'(HI_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

  logic            active;
  logic [BITS-1:0] shreg;
  logic [BW-1:0]   bit_idx;
  logic [PW-1:0]   ph_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      shreg   <= '0;
      bit_idx <= '0;
      ph_cnt  <= '0;
      sclk    <= 1'b1;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        // clock falls with the first bit already on the line
        active  <= 1'b1;
        mosi    <= din[BITS-1];
        shreg   <= din << 1;
        bit_idx <= '0;
        ph_cnt  <= '0;
        sclk    <= 1'b0;
      end else if (active) begin
        if (!sclk) begin
          if (ph_cnt == LO_END) begin
            sclk   <= 1'b1;
            ph_cnt <= '0;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end else if (ph_cnt == HI_END) begin
          ph_cnt <= '0;
          if (bit_idx == LAST_BIT) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            sclk    <= 1'b0;
            mosi    <= shreg[BITS-1];
            shreg   <= shreg << 1;
            bit_idx <= bit_idx + 1'b1;
          end
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_paced_host.sv
module spi_paced_host
  import spi_pace_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 50,
  parameter int unsigned SCK_LO_CYC = 2 * CLK_MHZ,
  parameter int unsigned SCK_HI_CYC = 2 * CLK_MHZ,
  parameter int unsigned BYTE_CYC   = 150 * CLK_MHZ,
  parameter int unsigned GUARD_CYC  = 120 * CLK_MHZ,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              periph_attn_n,
  input  logic              spi_miso,
  output logic              busy,
  output logic              read_pending
);
  localparam int unsigned TMAX = umax(BYTE_CYC, GUARD_CYC);
  localparam int unsigned CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] BYTE_LAST  = CW'(BYTE_CYC - 1);
  localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_CYC - 1);

  pace_state_e   state;
  logic          last_q;
  logic          cs_q;
  logic          rp_q;
  logic          load;
  logic          sh_done;
  logic          tmr_clear;
  logic [CW-1:0] tmr;
  logic          attn_s_n;
  logic          miso_s;

  spi_pace_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({periph_attn_n, spi_miso}),
    .q     ({attn_s_n, miso_s})
  );

  // One timer serves byte spacing and the guard: they never overlap.
  spi_pace_counter #(.MAX_CNT(TMAX)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .count (tmr)
  );

  spi_pace_shifter #(.LO_CYC(SCK_LO_CYC), .HI_CYC(SCK_HI_CYC), .BITS(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (in_data),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .done  (sh_done)
  );

  assign in_ready  = (state == ST_IDLE) || ((state == ST_GAP) && (tmr >= BYTE_LAST));
  assign load      = in_valid && in_ready;
  assign tmr_clear = load || (state == ST_WAIT_ATTN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      last_q <= 1'b0;
      cs_q   <= 1'b1;
      rp_q   <= 1'b0;
    end else begin
      rp_q <= !attn_s_n && miso_s && (state == ST_IDLE);
      unique case (state)
        ST_IDLE, ST_GAP: begin
          if (load) begin
            state  <= ST_SHIFT;
            last_q <= in_last;
            cs_q   <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (sh_done) begin
            if (last_q) begin
              state <= ST_WAIT_ATTN;
              cs_q  <= 1'b1;
            end else begin
              state <= ST_GAP;
            end
          end
        end
        ST_WAIT_ATTN: if (attn_s_n) state <= ST_GUARD;
        ST_GUARD:     if (tmr >= GUARD_LAST) state <= ST_IDLE;
        default:      state <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_n     = cs_q;
  assign busy         = (state != ST_IDLE);
  assign read_pending = rp_q;
endmodule

// File: rtl/spi_paced_host_chk.sv
module spi_paced_host_chk #(
  parameter int unsigned SCK_LO_CYC = 2,
  parameter int unsigned SCK_HI_CYC = 2,
  parameter int unsigned GUARD_CYC  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic attn_n,
  input logic in_ready,
  input logic busy
);
  logic [31:0] lo_run;
  logic [31:0] gap_run;
  logic        armed;
  logic        cs_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run  <= '0;
      gap_run <= 32'(GUARD_CYC);
      armed   <= 1'b0;
      cs_prev <= 1'b1;
    end else begin
      cs_prev <= cs_n;
      if (sclk) lo_run <= '0;
      else if (lo_run != 32'hFFFF_FFFF) lo_run <= lo_run + 1;
      if (cs_n && !cs_prev) begin
        armed   <= 1'b1;
        gap_run <= '0;
      end else if (armed) begin
        if (attn_n) armed <= 1'b0;
      end else if (gap_run < 32'(GUARD_CYC)) begin
        gap_run <= gap_run + 1;
      end
    end
  end

  a_r2_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (lo_run >= 32'(SCK_LO_CYC)));

  a_r3_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r4_clock_under_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> !cs_n);

  a_r6_idle_clock_between_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !cs_n) |-> sclk);

  a_r7_guard_before_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (!armed && gap_run >= 32'(GUARD_CYC)));

  a_r8_ready_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && cs_n) |-> !busy);
endmodule

bind spi_paced_host spi_paced_host_chk #(
  .SCK_LO_CYC (SCK_LO_CYC),
  .SCK_HI_CYC (SCK_HI_CYC),
  .GUARD_CYC  (GUARD_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (spi_cs_n),
  .sclk     (spi_sclk),
  .mosi     (spi_mosi),
  .attn_n   (periph_attn_n),
  .in_ready (in_ready),
  .busy     (busy)
);

// File: tb/tb_spi_paced_host.sv
`timescale 1ns/1ps
module tb_spi_paced_host;
  localparam int LO = 3, HI = 2, BYTE = 60, GRD = 40;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, in_valid, in_last, in_ready;
  logic [7:0] in_data;
  logic       spi_cs_n, spi_sclk, spi_mosi, attn_n, spi_miso, busy, read_pending;

  spi_paced_host #(.CLK_MHZ(1), .SCK_LO_CYC(LO), .SCK_HI_CYC(HI),
                   .BYTE_CYC(BYTE), .GUARD_CYC(GRD), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .periph_attn_n(attn_n),
    .spi_miso(spi_miso), .busy(busy), .read_pending(read_pending));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  int         len_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // ---------------- monitor / scoreboard ----------------
  logic       prev_sclk = 1'b1, prev_cs = 1'b1, prev_attn = 1'b1;
  int         lo_len = 0, hi_len = 0, bitcnt = 0, nbytes = 0, last_start = 0;
  int         attn_cyc = 0;
  bit         recov = 0, attn_seen = 0;
  logic [7:0] shreg = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!spi_sclk && prev_sclk && !spi_cs_n) begin
        if (bitcnt != 0) chk(hi_len == HI, "R2 high phase", hi_len, HI);
        else begin
          if (nbytes > 0) chk(cyc - last_start >= BYTE, "R5 byte spacing", cyc - last_start, BYTE);
          last_start = cyc;
        end
      end
      if (spi_sclk && !prev_sclk && !spi_cs_n) begin
        chk(lo_len == LO, "R2 low phase", lo_len, LO);
        shreg = {shreg[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt == 8) begin
          bitcnt = 0;
          nbytes++;
          if (exp_q.size() == 0) chk(1'b0, "R1 unexpected byte", shreg, -1);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(shreg == e, "R1 byte MSB first", shreg, e);
          end
        end
      end
      lo_len = spi_sclk ? 0 : lo_len + 1;
      hi_len = spi_sclk ? hi_len + 1 : 0;

      if (!spi_cs_n && (bitcnt != 0 || !spi_sclk))
        chk(!in_ready, "R6 ready low while shifting", in_ready, 0);
      if (spi_cs_n) chk(spi_sclk, "R2 clock rests high", spi_sclk, 1);

      if (spi_cs_n && !prev_cs) begin
        int e;
        e = (len_q.size() != 0) ? len_q.pop_front() : -1;
        chk(nbytes == e && bitcnt == 0, "R4 R10 bytes under one select", nbytes, e);
        nbytes = 0;
        recov = 1;
        attn_seen = 0;
      end
      if (recov && attn_n && !prev_attn && !attn_seen) begin
        attn_cyc = cyc;
        attn_seen = 1;
      end
      if (recov) begin
        chk(busy && !in_ready, "R8 busy through recovery", {busy, in_ready}, 2);
        if (attn_seen && cyc >= attn_cyc + GRD) recov = 0;
      end
      if (!spi_cs_n && prev_cs && attn_seen) begin
        chk(!recov && (cyc - attn_cyc >= GRD), "R7 guard after attention", cyc - attn_cyc, GRD);
      end
      if (!spi_cs_n && prev_cs) chk(busy, "R8 busy during message", busy, 1);
    end
    prev_sclk = spi_sclk;
    prev_cs   = spi_cs_n;
    prev_attn = attn_n;
  end

  // ---------------- driver ----------------
  task automatic begin_msg(input int n);
    len_q.push_back(n);
  endtask

  task automatic push(input logic [7:0] b, input bit last, input int pre, input bit first);
    exp_q.push_back(b);
    repeat (pre) tick();
    in_valid = 1'b1; in_data = b; in_last = last;
    while (!in_ready) tick();
    tick();
    in_valid = 1'b0;
    if (first) attn_n = 1'b0;
  endtask

  task automatic end_msg(input int dly);
    while (!spi_cs_n) tick();
    repeat (dly) tick();
    attn_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 0; in_valid = 0; in_data = '0; in_last = 0; attn_n = 1; spi_miso = 0;
    repeat (5) tick();
    rst_n = 1;
    tick(); tick();
    chk(spi_cs_n, "R4 reset select high", spi_cs_n, 1);
    chk(spi_sclk, "R2 reset clock high", spi_sclk, 1);
    chk(!busy, "R8 reset not busy", busy, 0);
    chk(in_ready, "R6 reset ready", in_ready, 1);
    chk(!read_pending, "R9 reset no request", read_pending, 0);

    // single-byte message, quick attention release
    begin_msg(1);
    push(8'hA5, 1, 0, 1);
    end_msg(0);

    // three bytes back to back; read request held during the message
    begin_msg(3);
    push(8'h3C, 0, 0, 1);
    spi_miso = 1'b1;
    push(8'hC3, 0, 0, 0);
    chk(!read_pending, "R9 no request report inside message", read_pending, 0);
    spi_miso = 1'b0;
    push(8'h01, 1, 0, 0);
    end_msg(25);

    // next message already waiting during recovery, with a long idle inside
    begin_msg(4);
    push(8'hFF, 0, 0, 1);
    push(8'h00, 0, 70, 0);
    push(8'h80, 0, 0, 0);
    push(8'h7E, 1, 5, 0);
    end_msg(5);

    while (busy) tick();
    attn_n = 1'b0; spi_miso = 1'b1;
    repeat (5) tick();
    chk(read_pending, "R9 request reported when idle", read_pending, 1);
    chk(spi_cs_n && !busy, "R9 request starts no transfer", {spi_cs_n, busy}, 2);
    spi_miso = 1'b0;
    repeat (5) tick();
    chk(!read_pending, "R9 request clears", read_pending, 0);
    attn_n = 1'b1;
    repeat (3) tick();

    begin_msg(2);
    push(8'h81, 0, 0, 1);
    push(8'h18, 1, 0, 0);
    end_msg(3);

    while (busy) tick();
    repeat (3) tick();
    chk(exp_q.size() == 0, "R1 all bytes delivered", exp_q.size(), 0);
    chk(len_q.size() == 0, "R4 all messages closed", len_q.size(), 0);
    finish_run();
  end
endmodule